// File: doc/BRIEF.md
# Triggered Sample Capture Buffer

This block is the capture engine of an on-chip logic analyzer. Once armed, it writes the probe bus into a circular sample store on every clock. It waits for a trigger and then keeps writing until the window holds a programmed amount of history before the trigger and the rest after it. Completion freezes the store. A read port then returns the window, oldest sample first.

The trigger offset, the trigger kind and the repeat choice are taken from the inputs in the cycle the arm request is accepted. The trigger is either immediate or a rising edge on one selected probe bit. In repeat mode, reading out the last sample of a window starts the next capture with no further request, so an intermittent event can be caught again and again. The window length is a power of two, 1024 samples by default.

Top module: `trig_capture`

## Requirements
- R1: After reset the status output reads idle (code 0) and `rd_valid_o` is low.
- R2: An arm request is accepted in idle or done. From the next clock the probe is written on every cycle. The status reads pre-fill (code 1), or waiting for trigger (code 2) when the trigger offset P is 0.
- R3: The status stays pre-fill until P samples have been written after arming. Any trigger condition during that time is ignored.
- R4: In edge mode (`immed_i` low), the trigger sample is the first sample, at index P or later, whose selected bit `probe_i[trig_sel_i]` is 1 while the bit was 0 in the sample just before it. The first sample after arming never counts as an edge.
- R5: In immediate mode (`immed_i` high), the trigger sample is the first sample eligible under R3, which is sample index P after arming.
- R6: From the trigger sample onward, exactly DEPTH−P samples are written, the trigger sample among them, while the status reads post-trigger (code 3). The status then reads done (code 4) and no further writes occur.
- R7: In done, `rd_valid_o` is high and `rd_data_o` shows the oldest stored sample. Each cycle with `rd_en_i` high advances to the next sample. The trigger sample appears at read index P.
- R8: The read that takes the last of the DEPTH samples returns the block to idle when repeat was off at arming. When repeat was on, the same read re-arms the block at once, with the settings latched at the original arm.
- R9: The status codes are fixed: 0 idle, 1 pre-fill, 2 waiting, 3 post-trigger, 4 done.
- R10: Changes on `trig_pos_i`, `immed_i`, `trig_sel_i` and `repeat_i` after an accepted arm have no effect on the capture or on automatic re-arms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_i | input | PROBE_W | Probe bus being sampled |
| arm_i | input | 1 | Arm request, accepted in idle or done |
| trig_pos_i | input | ADDR_W | Number of pre-trigger samples P |
| immed_i | input | 1 | 1: immediate trigger, 0: rising edge trigger |
| trig_sel_i | input | SEL_W | Probe bit watched for the rising edge |
| repeat_i | input | 1 | Re-arm after each full readout |
| rd_en_i | input | 1 | Advance read pointer by one sample |
| rd_data_o | output | PROBE_W | Sample at the current read position |
| rd_valid_o | output | 1 | High while captured data can be read |
| state_o | output | 3 | Status code |

## Verification
In repeat mode, the last read of one window and the re-arm for the next fall in the same cycle. The first sample of the new capture is written on the very next clock. The bench keeps the read enable high through the final read and drives the first sample of the next pattern in that same cycle. It then judges the second window only through its status sequence and its readout, while the setting inputs hold deliberately different values. Immediate triggering at the last pre-fill step is a second coincidence, covered by the full sweep of trigger offsets.

// File: rtl/trig_capture_pkg.sv
package trig_capture_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_FILL = 3'd1,
    ST_WAIT = 3'd2,
    ST_POST = 3'd3,
    ST_DONE = 3'd4
  } cap_state_e;
endpackage

// File: rtl/tc_sample_ram.sv
module tc_sample_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // storage array has no reset; contents are only read after a full window
  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/tc_edge_detect.sv
module tc_edge_detect #(
  parameter int PROBE_W = 8,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               smp_en,
  input  logic [PROBE_W-1:0] probe,
  input  logic [SEL_W-1:0]   sel,
  output logic               rise
);
  logic cur_bit;
  logic prev_q, prev_d;
  logic vld_q, vld_d;

  assign cur_bit = probe[sel];

  always_comb begin
    prev_d = prev_q;
    vld_d  = vld_q;
    if (clr) begin
      vld_d = 1'b0;
    end else if (smp_en) begin
      prev_d = cur_bit;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      vld_q  <= vld_d;
    end
  end

  assign rise = smp_en & vld_q & ~prev_q & cur_bit;

  // R4: an edge needs a sample taken in the cycle before
  a_r4_edge_has_history: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> $past(smp_en));
endmodule

// File: rtl/tc_seq.sv
module tc_seq
  import trig_capture_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic [ADDR_W-1:0] pos_i,
  input  logic              immed_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              rep_i,
  input  logic              rise_i,
  input  logic              rd_en_i,
  output cap_state_e        state_o,
  output logic              smp_en_o,
  output logic              start_o,
  output logic [ADDR_W-1:0] wptr_o,
  output logic [ADDR_W-1:0] rptr_o,
  output logic [SEL_W-1:0]  sel_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] LAST_RD = (ADDR_W+1)'(DEPTH - 1);
  localparam logic [ADDR_W:0] FULL    = (ADDR_W+1)'(DEPTH);

  cap_state_e        state_q, state_d;
  logic [ADDR_W:0]   cnt_q, cnt_d;
  logic [ADDR_W-1:0] wptr_q, wptr_d;
  logic [ADDR_W-1:0] rptr_q, rptr_d;
  logic [ADDR_W-1:0] pos_q;
  logic              immed_q, rep_q;
  logic [SEL_W-1:0]  sel_q;

  logic              arm_ok, last_rd, rearm, hit, smp_en;
  logic [ADDR_W:0]   rem;
  logic [ADDR_W-1:0] first_pos;

  assign smp_en    = (state_q == ST_FILL) || (state_q == ST_WAIT) || (state_q == ST_POST);
  assign arm_ok    = arm_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign last_rd   = (state_q == ST_DONE) && rd_en_i && (cnt_q == LAST_RD);
  assign rearm     = last_rd && rep_q && !arm_ok;
  assign hit       = immed_q | rise_i;
  assign rem       = FULL - {1'b0, pos_q} - (ADDR_W+1)'(1);
  assign first_pos = arm_ok ? pos_i : pos_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    if (smp_en) wptr_d = wptr_q + 1'b1;
    unique case (state_q)
      ST_FILL: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q + 1'b1 == {1'b0, pos_q}) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (hit) begin
          if (rem == '0) begin
            state_d = ST_DONE;
            cnt_d   = '0;
            rptr_d  = wptr_q + 1'b1;
          end else begin
            state_d = ST_POST;
            cnt_d   = rem;
          end
        end
      end
      ST_POST: begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == (ADDR_W+1)'(1)) begin
          state_d = ST_DONE;
          cnt_d   = '0;
          rptr_d  = wptr_q + 1'b1;
        end
      end
      ST_DONE: begin
        if (rd_en_i) begin
          rptr_d = rptr_q + 1'b1;
          cnt_d  = cnt_q + 1'b1;
          if (last_rd) state_d = ST_IDLE;
        end
      end
      default: ;
    endcase
    if (arm_ok || rearm) begin
      state_d = (first_pos == '0) ? ST_WAIT : ST_FILL;
      cnt_d   = '0;
      wptr_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wptr_q  <= '0;
      rptr_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
    end
  end

  // settings are captured only when an external arm is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      immed_q <= 1'b0;
      sel_q   <= '0;
      rep_q   <= 1'b0;
    end else if (arm_ok) begin
      pos_q   <= pos_i;
      immed_q <= immed_i;
      sel_q   <= sel_i;
      rep_q   <= rep_i;
    end
  end

  assign state_o  = state_q;
  assign smp_en_o = smp_en;
  assign start_o  = arm_ok | rearm;
  assign wptr_o   = wptr_q;
  assign rptr_o   = rptr_q;
  assign sel_o    = sel_q;

  a_r9_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    state_q <= ST_DONE);

  // R3: pre-fill can only advance to waiting, never straight to capture
  a_r3_fill_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL) |=> (state_q == ST_FILL || state_q == ST_WAIT));

  // R5: immediate mode leaves the waiting state after one cycle
  a_r5_immed_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && immed_q) |=> (state_q == ST_POST || state_q == ST_DONE));

  // R6: writes stop once the window is complete
  a_r6_done_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_DONE && state_q == ST_DONE) |-> $stable(wptr_q));

  // R8: one-shot capture returns to idle after the final read
  a_r8_oneshot_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && rd_en_i && cnt_q == LAST_RD && !rep_q && !arm_i)
    |=> (state_q == ST_IDLE));
endmodule

// File: rtl/trig_capture.sv
module trig_capture
  import trig_capture_pkg::*;
#(
  parameter int PROBE_W = 8,
  parameter int ADDR_W  = 10,
  localparam int SEL_W  = (PROBE_W > 1) ? $clog2(PROBE_W) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PROBE_W-1:0] probe_i,
  input  logic               arm_i,
  input  logic [ADDR_W-1:0]  trig_pos_i,
  input  logic               immed_i,
  input  logic [SEL_W-1:0]   trig_sel_i,
  input  logic               repeat_i,
  input  logic               rd_en_i,
  output logic [PROBE_W-1:0] rd_data_o,
  output logic               rd_valid_o,
  output logic [2:0]         state_o
);
  cap_state_e        state;
  logic              smp_en, start, rise;
  logic [ADDR_W-1:0] wptr, rptr;
  logic [SEL_W-1:0]  sel_q;

  tc_seq #(
    .ADDR_W (ADDR_W),
    .SEL_W  (SEL_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm_i),
    .pos_i    (trig_pos_i),
    .immed_i  (immed_i),
    .sel_i    (trig_sel_i),
    .rep_i    (repeat_i),
    .rise_i   (rise),
    .rd_en_i  (rd_en_i),
    .state_o  (state),
    .smp_en_o (smp_en),
    .start_o  (start),
    .wptr_o   (wptr),
    .rptr_o   (rptr),
    .sel_o    (sel_q)
  );

  tc_edge_detect #(
    .PROBE_W (PROBE_W),
    .SEL_W   (SEL_W)
  ) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (start),
    .smp_en (smp_en),
    .probe  (probe_i),
    .sel    (sel_q),
    .rise   (rise)
  );

  tc_sample_ram #(
    .DATA_W (PROBE_W),
    .ADDR_W (ADDR_W)
  ) u_ram (
    .clk   (clk),
    .we    (smp_en),
    .waddr (wptr),
    .wdata (probe_i),
    .raddr (rptr),
    .rdata (rd_data_o)
  );

  assign rd_valid_o = (state == ST_DONE);
  assign state_o    = state;

  // R7: read data is offered only in done
  a_r7_valid_only_done: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> (state_o == 3'd4));
endmodule

// File: tb/trig_capture_tb.sv
module trig_capture_tb;
  localparam int CLK_P = 10;
  localparam int PW    = 4;
  localparam int AW    = 4;
  localparam int D     = 1 << AW;

  logic          clk, rst_n;
  logic [PW-1:0] probe_i;
  logic          arm_i, immed_i, repeat_i, rd_en_i;
  logic [AW-1:0] trig_pos_i;
  logic [1:0]    trig_sel_i;
  logic [PW-1:0] rd_data_o;
  logic          rd_valid_o;
  logic [2:0]    state_o;

  int vectors = 0;
  int fails   = 0;

  trig_capture #(.PROBE_W(PW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .probe_i(probe_i), .arm_i(arm_i),
    .trig_pos_i(trig_pos_i), .immed_i(immed_i), .trig_sel_i(trig_sel_i),
    .repeat_i(repeat_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .state_o(state_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // probe pattern: edge mode forces the selected bit high at sample 0,
  // pulses it at P-1 (inside pre-fill) and raises it for good at tt
  function automatic logic [PW-1:0] gen(int k, int seed, bit e, int sel, int pos, int tt);
    logic [PW-1:0] v;
    bit b;
    v = PW'((k * 5 + seed) % 16);
    b = (k == 0) || (pos >= 3 && k == pos - 1) || (k >= tt);
    if (e) v[sel] = b;
    return v;
  endfunction

  function automatic int exp_state(int k, int pos, int t, int total);
    if (k < pos)   return 1;
    if (k <= t)    return 2;
    if (k < total) return 3;
    return 4;
  endfunction

  task automatic run(input int pos, input bit e, input int sel, input int seed,
                     input bit rep, input bit do_arm, input bit do_read);
    int tt, t, total, es;
    string tag;
    tt    = ((pos < 3) ? 3 : pos + 1) + pos % 3;
    t     = e ? tt : pos;
    total = t + D - pos;
    if (do_arm) begin
      @(negedge clk);
      probe_i    = '0;
      trig_pos_i = AW'(pos);
      immed_i    = !e;
      trig_sel_i = 2'(sel);
      repeat_i   = rep;
      arm_i      = 1'b1;
      @(posedge clk);
      @(negedge clk);
      arm_i      = 1'b0;
      // R10: scramble the settings after the accepted arm
      trig_pos_i = AW'(15 - pos);
      immed_i    = e;
      trig_sel_i = 2'(sel + 1);
      repeat_i   = !rep;
    end
    for (int k = 0; k <= total; k++) begin
      es = exp_state(k, pos, t, total);
      if (k == 0)          tag = "R2";
      else if (k < pos)    tag = "R3";
      else if (k <= t)     tag = e ? "R4" : "R5";
      else if (k < total)  tag = "R6";
      else                 tag = "R9";
      chk(int'(state_o) == es, tag, int'(state_o), es);
      if (k < total) begin
        probe_i = gen(k, seed, e, sel, pos, tt);
        @(posedge clk);
        @(negedge clk);
      end
    end
    if (do_read) begin
      for (int i = 0; i < D; i++) begin
        chk(rd_valid_o == 1'b1, "R7", int'(rd_valid_o), 1);
        es = int'(gen(t - pos + i, seed, e, sel, pos, tt));
        chk(int'(rd_data_o) == es, do_arm ? "R7" : "R10", int'(rd_data_o), es);
        rd_en_i = 1'b1;
        probe_i = PW'((i * 7 + 9) % 16);   // R6: ignored, writes are stopped
        @(posedge clk);
        @(negedge clk);
      end
      rd_en_i = 1'b0;
      es = rep ? ((pos == 0) ? 2 : 1) : 0;
      chk(int'(state_o) == es, "R8", int'(state_o), es);
      if (!rep) chk(rd_valid_o == 1'b0, "R8", int'(rd_valid_o), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; probe_i = '0; arm_i = 1'b0; trig_pos_i = '0;
    immed_i = 1'b0; trig_sel_i = '0; repeat_i = 1'b0; rd_en_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(state_o == 3'd0, "R1", int'(state_o), 0);
    chk(rd_valid_o == 1'b0, "R1", int'(rd_valid_o), 0);

    // sweep every trigger offset in both trigger kinds
    for (int p = 0; p < D; p++) begin
      for (int m = 0; m < 2; m++) begin
        run(p, bit'(m), p % 4, p * 3 + m, 1'b0, 1'b1, 1'b1);
      end
    end

    // repeat mode, edge trigger: two automatic re-arms, then re-arm by request from done
    run(5, 1'b1, 2, 11, 1'b1, 1'b1, 1'b1);
    run(5, 1'b1, 2, 12, 1'b1, 1'b0, 1'b1);
    run(5, 1'b1, 2, 13, 1'b1, 1'b0, 1'b0);
    run(9, 1'b0, 1, 14, 1'b0, 1'b1, 1'b1);

    // repeat mode, immediate trigger with zero offset
    run(0, 1'b0, 3, 20, 1'b1, 1'b1, 1'b1);
    run(0, 1'b0, 3, 21, 1'b1, 1'b0, 1'b0);
    run(15, 1'b1, 0, 22, 1'b0, 1'b1, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule